// File: doc/BRIEF.md
# Spread-Spectrum Modulation Offset Generator

This block produces the signed offset that a fractional PLL adds to its feedback divider to spread the output spectrum. A 128-point triangular profile is walked one point at a time. A point is taken after a programmable number of reference ticks, so the modulation rate is the reference rate divided by the reference divider, by 128 and by that tick count. The triangle is scaled by a 5-bit amplitude code, each code step being worth 0.1 % of the output frequency. The wave either sits centred on zero or lies entirely below zero (down spread).

Software drives a single 16-bit control word. It brings the modulator up in this order: program the amplitude and step period, clear bypass and disable, pulse the modulator reset, then release it. The offset is a level, not a stream. It holds a new value whenever the profile position moves, and it is forced to zero whenever modulation is not running.

Top module: `ssc_modulator`

## Requirements
- R1: While the bypass bit (bit 0), disable bit (bit 1) or modulator reset bit (bit 2) of `mod_ctrl` is 1, `fb_offset` is 0 in the same cycle. The profile position returns to point 0 and the tick count to 0.
- R2: Control word layout: bit 3 selects down spread (1) or centre spread (0), bits 7:4 hold the step period `dv`, and bits 12:8 hold the amplitude code `amp`.
- R3: While running, the profile advances one point on every `dv`-th clock with `ref_tick` high. A `dv` of 0 behaves as 1.
- R4: Clocks with `ref_tick` low neither count toward a step nor move the profile.
- R5: The profile has 128 points. The point after 127 is point 0.
- R6: In centre spread, point p gives `fb_offset = amp*(2*w-63)`, where w = p for p < 64 and w = 127-p otherwise. The range is symmetric about zero.
- R7: In down spread, point p gives `fb_offset = -amp*2*w`. It is never positive, and it peaks at a magnitude of amp*126.
- R8: Modulation runs only when `ref_div` lies between 1 and 6 inclusive. Otherwise the block behaves as in R1.
- R9: Changes to `amp`, `dv` and the direction bit made while running take effect only when the profile wraps from point 127 to point 0.
- R10: When bypass, disable, reset and an invalid `ref_div` are all removed, the new run starts at point 0 with the fields present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| mod_ctrl | input | 16 | Modulation control word (fields per R1, R2) |
| ref_div | input | 6 | Reference divider setting of the PLL |
| fb_offset | output | 14 | Signed offset added to the feedback divider |

## Verification
The hardest state to reach is a field change that is pending at the wrap. New amplitude, direction and period values must be ignored for the rest of the current 128-point period and then picked up exactly at point 0. The stimulus rewrites all three fields part-way through a period. It then follows every point across the wrap, checking the old scaling up to point 127 and the new scaling and step period from point 0 on. A sweep over every step period in both directions, with sparse reference ticks and varied reference dividers, covers the rest of the profile arithmetic.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Control word bit positions
  localparam int unsigned BIT_BYP = 0;
  localparam int unsigned BIT_DIS = 1;
  localparam int unsigned BIT_RST = 2;
  localparam int unsigned BIT_DN  = 3;
  localparam int unsigned DV_LSB  = 4;
  localparam int unsigned AMP_LSB = 8;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned RDIV_W  = 6;
endpackage

// File: rtl/ssc_ctrl_decode.sv
module ssc_ctrl_decode
  import ssc_pkg::*;
#(
  parameter int unsigned DV_W       = 4,
  parameter int unsigned AMP_W      = 5,
  parameter int unsigned MAX_REFDIV = 6
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [RDIV_W-1:0] rdiv,
  output logic              run,
  output logic              dn,
  output logic [DV_W-1:0]   dv,
  output logic [AMP_W-1:0]  amp
);
  logic rdiv_ok;

  always_comb begin
    rdiv_ok = (rdiv != '0) && (rdiv <= RDIV_W'(MAX_REFDIV));
    run     = rdiv_ok && !ctrl[BIT_BYP] && !ctrl[BIT_DIS] && !ctrl[BIT_RST];
    dn      = ctrl[BIT_DN];
    dv      = ctrl[DV_LSB +: DV_W];
    amp     = ctrl[AMP_LSB +: AMP_W];
  end
endmodule

// File: rtl/ssc_profile_seq.sv
module ssc_profile_seq #(
  parameter int unsigned PTS_W = 7,
  parameter int unsigned DV_W  = 4,
  parameter int unsigned AMP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ref_tick,
  input  logic [DV_W-1:0]  dv_in,
  input  logic [AMP_W-1:0] amp_in,
  input  logic             dn_in,
  output logic [PTS_W-1:0] pos,
  output logic [AMP_W-1:0] amp_sh,
  output logic             dn_sh
);
  localparam logic [PTS_W-1:0] LAST = '1;

  logic [DV_W-1:0] cnt;
  logic [DV_W-1:0] dv_sh;
  logic [DV_W-1:0] cnt_last;
  logic            adv;
  logic            wrap;

  always_comb begin
    cnt_last = (dv_sh == '0) ? '0 : dv_sh - 1'b1;
    adv      = run && ref_tick && (cnt == cnt_last);
    wrap     = adv && (pos == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pos    <= '0;
      dv_sh  <= '0;
      amp_sh <= '0;
      dn_sh  <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      pos    <= '0;
      dv_sh  <= dv_in;
      amp_sh <= amp_in;
      dn_sh  <= dn_in;
    end else if (ref_tick) begin
      if (adv) begin
        cnt <= '0;
        pos <= pos + 1'b1;
        if (wrap) begin
          dv_sh  <= dv_in;
          amp_sh <= amp_in;
          dn_sh  <= dn_in;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1 / R10: idle returns the profile to its first point
  p_idle_home_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos == '0));
  // R4: no tick, no movement
  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ref_tick) |=> $stable(pos));
  // R3: partial count holds the point
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ref_tick && !adv) |=> $stable(pos));
  // R5: a step moves exactly one point, wrapping at the end
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pos == PTS_W'($past(pos) + 1'b1)));
  // R9: settings latched only at the wrap
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(amp_sh) && $stable(dn_sh) && $stable(dv_sh)));
endmodule

// File: rtl/ssc_shape_scale.sv
module ssc_shape_scale #(
  parameter int unsigned PTS_W = 7,
  parameter int unsigned AMP_W = 5,
  parameter int unsigned OFS_W = AMP_W + PTS_W + 2
) (
  input  logic                    run,
  input  logic [PTS_W-1:0]        pos,
  input  logic [AMP_W-1:0]        amp,
  input  logic                    dn,
  output logic signed [OFS_W-1:0] offset
);
  localparam int unsigned SH_W = PTS_W + 1;
  localparam logic signed [SH_W-1:0] MID = SH_W'((2 ** (PTS_W - 1)) - 1);

  logic [PTS_W-2:0]               w;
  logic signed [SH_W-1:0]         twice_w;
  logic signed [SH_W-1:0]         shape;
  logic signed [AMP_W+SH_W:0]     prod;

  always_comb begin
    w       = pos[PTS_W-1] ? ~pos[PTS_W-2:0] : pos[PTS_W-2:0];
    twice_w = $signed({1'b0, w, 1'b0});
    shape   = dn ? -twice_w : (twice_w - MID);
    prod    = $signed({1'b0, amp}) * shape;
    offset  = run ? OFS_W'(prod) : '0;
  end
endmodule

// File: rtl/ssc_modulator.sv
module ssc_modulator
  import ssc_pkg::*;
#(
  parameter int unsigned PTS_W      = 7,
  parameter int unsigned DV_W       = 4,
  parameter int unsigned AMP_W      = 5,
  parameter int unsigned MAX_REFDIV = 6,
  parameter int unsigned OFS_W      = AMP_W + PTS_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic [CTRL_W-1:0]       mod_ctrl,
  input  logic [RDIV_W-1:0]       ref_div,
  output logic signed [OFS_W-1:0] fb_offset
);
  localparam int PEAK = (2 ** AMP_W - 1) * (2 ** PTS_W - 2);

  logic             run;
  logic             dn_live;
  logic [DV_W-1:0]  dv_live;
  logic [AMP_W-1:0] amp_live;
  logic [PTS_W-1:0] pos;
  logic [AMP_W-1:0] amp_sh;
  logic             dn_sh;

  ssc_ctrl_decode #(.DV_W(DV_W), .AMP_W(AMP_W), .MAX_REFDIV(MAX_REFDIV)) u_dec (
    .ctrl(mod_ctrl), .rdiv(ref_div), .run(run),
    .dn(dn_live), .dv(dv_live), .amp(amp_live)
  );

  ssc_profile_seq #(.PTS_W(PTS_W), .DV_W(DV_W), .AMP_W(AMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
    .dv_in(dv_live), .amp_in(amp_live), .dn_in(dn_live),
    .pos(pos), .amp_sh(amp_sh), .dn_sh(dn_sh)
  );

  ssc_shape_scale #(.PTS_W(PTS_W), .AMP_W(AMP_W), .OFS_W(OFS_W)) u_shape (
    .run(run), .pos(pos), .amp(amp_sh), .dn(dn_sh), .offset(fb_offset)
  );

  // R7: down spread never goes above zero
  p_down_nonpos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sh |-> (fb_offset <= 0));
  // R6: offset magnitude bounded by the full-scale span
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_offset <= PEAK) && (fb_offset >= -PEAK));
  // R1: a held control bit forces a zero offset
  p_zero_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_ctrl[BIT_BYP] || mod_ctrl[BIT_DIS] || mod_ctrl[BIT_RST]) |-> (fb_offset == 0));
endmodule

// File: tb/ssc_modulator_bench.sv
module ssc_modulator_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_tick = 1'b0;
  logic [15:0]       mod_ctrl = 16'h0004;
  logic [5:0]        ref_div = 6'd1;
  logic signed [13:0] fb_offset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ssc_modulator u_ssc_modulator (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .mod_ctrl(mod_ctrl), .ref_div(ref_div), .fb_offset(fb_offset)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] mk(bit byp, bit dis, bit rst, bit dn, int dv, int amp);
    return {3'b000, 5'(amp), 4'(dv), dn, rst, dis, byp};
  endfunction

  function automatic int model(int amp, bit dn, int p);
    int w;
    w = (p < 64) ? p : 127 - p;
    return dn ? -(amp * 2 * w) : amp * (2 * w - 63);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // start a run from the reset state; returns with release applied at a negedge
  task automatic start(int dv, int amp, bit dn);
    ref_tick = 1'b0;
    mod_ctrl = mk(0, 0, 1, dn, dv, amp);
    @(negedge clk);
    @(negedge clk);
    mod_ctrl = mk(0, 0, 0, dn, dv, amp);
  endtask

  // drive ticks every te cycles for ncyc cycles, checking each point
  task automatic follow(string req, int dv, int amp, bit dn, int ncyc, int te);
    int ticks = 0;
    int dve = (dv == 0) ? 1 : dv;
    for (int i = 0; i < ncyc; i++) begin
      ref_tick = ((i % te) == 0);
      if (ref_tick) ticks++;
      @(negedge clk);
      chk(req, fb_offset, model(amp, dn, (ticks / dve) % 128));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", fb_offset, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 modulator reset holds zero", fb_offset, 0);

    // R2 R3 R5 R6 R7: every period in both directions
    for (int dv = 0; dv < 16; dv++) begin
      for (int d = 0; d < 2; d++) begin
        int amp = (dv * 7 + d * 13 + 5) % 32;
        if (dv == 15) amp = 31;
        ref_div = 6'(1 + (dv % 6));
        start(dv, amp, d[0]);
        follow(d ? "R7 down spread" : "R6 centre spread", dv, amp, d[0],
               ((dv == 0) ? 1 : dv) * 130, 1);
      end
    end
    ref_div = 6'd3;

    // R4: sparse ticks
    start(2, 17, 1'b0);
    follow("R4 tick gating", 2, 17, 1'b0, 900, 3);

    // R8: invalid reference dividers
    ref_div = 6'd0;
    start(1, 20, 1'b0);
    for (int i = 0; i < 20; i++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      chk("R8 ref_div 0", fb_offset, 0);
    end
    ref_div = 6'd7;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R8 ref_div 7", fb_offset, 0);
    end
    ref_div = 6'd6;
    follow("R8 R10 ref_div 6 start", 1, 20, 1'b0, 40, 1);

    // R1 R10: bypass and disable mid-run, restart from point 0
    ref_div = 6'd2;
    for (int b = 0; b < 2; b++) begin
      start(1, 9, 1'b1);
      follow("R1 run before stop", 1, 9, 1'b1, 50, 1);
      mod_ctrl = mk(b == 0, b == 1, 0, 1, 1, 9);
      ref_tick = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk(b ? "R1 disable zero" : "R1 bypass zero", fb_offset, 0);
      end
      mod_ctrl = mk(0, 0, 0, 1, 1, 9);
      follow("R10 restart at point 0", 1, 9, 1'b1, 60, 1);
    end

    // R9: fields rewritten mid-period take effect at the wrap
    start(1, 10, 1'b0);
    begin
      int ticks = 0;
      for (int i = 0; i < 128 + 300; i++) begin
        ref_tick = 1'b1;
        ticks++;
        if (i == 20) mod_ctrl = mk(0, 0, 0, 1, 2, 25);
        @(negedge clk);
        if (ticks < 128)
          chk("R9 old fields until wrap", fb_offset, model(10, 1'b0, ticks));
        else
          chk("R9 new fields from wrap", fb_offset, model(25, 1'b1, ((ticks - 128) / 2) % 128));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule